// File: doc/BRIEF.md
# Hysteresis Flow-Controlled Link Receive Buffer

This block sits at the receiving end of a point-to-point link where the sender can have several phits on the wire at any moment. Each arriving phit is stored in a first-in first-out buffer. The local consumer drains the buffer through a valid/ready pair. Flow-control symbols are sent back along the reverse path. A halt symbol goes out when the buffer fills past an upper threshold. A resume symbol goes out when the buffer has drained down to a lower threshold. Between the two thresholds the link keeps whatever state it last had. This band prevents the symbols from chattering on every phit.

Once the sender sees a halt symbol, it needs a bounded number of cycles to stop injecting. The space between the upper threshold and the full buffer must absorb every phit that is already in flight during that round trip. The parameters are checked at elaboration against this rule. If a phit still arrives while the buffer is full, that phit is discarded and a sticky error flag is raised.

Top module: `wm_link_rx`

## Requirements
- R1: After reset the buffer is empty (`level` = 0, `out_valid` = 0), the link state is resume (`link_go` = 1), no symbol is being sent (`fc_valid` = 0) and `overflow_err` = 0.
- R2: Phits leave in the order they were accepted. `out_valid` is 1 exactly when `level` is non-zero, and a phit is removed on a cycle with `out_valid` and `out_ready` both 1.
- R3: While `link_go` = 1, the clock edge after `level` reaches HIGH_MARK (default 24) or more drives `fc_valid` = 1 with `fc_go` = 0 (halt) for exactly one cycle and sets `link_go` to 0.
- R4: While `link_go` = 0, the clock edge after `level` drops to LOW_MARK (default 8) or less drives `fc_valid` = 1 with `fc_go` = 1 (resume) for exactly one cycle and sets `link_go` to 1.
- R5: A symbol is sent only when the link state changes. No symbol is sent while `level` stays strictly between the two thresholds, and no symbol is repeated while the state holds.
- R6: `level` equals the number of stored phits (at most DEPTH, default 32) and changes by at most one per cycle.
- R7: When `in_valid` = 1 and the buffer is full, a phit that arrives on a cycle with no removal is discarded and `overflow_err` becomes 1. The flag then stays 1 until reset. A phit that arrives at full on a cycle with a removal is accepted.
- R8: If the sender stops injecting within RTT_CYCLES (default 6) cycles of a halt symbol, the buffer never overflows. Elaboration rejects any DEPTH smaller than HIGH_MARK + RTT_CYCLES + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Phit arriving from the link this cycle |
| in_data | input | DATA_W | Arriving phit payload |
| out_ready | input | 1 | Consumer can take the head phit |
| out_valid | output | 1 | Head phit is present |
| out_data | output | DATA_W | Head phit payload |
| level | output | $clog2(DEPTH+1) | Current buffer occupancy |
| fc_valid | output | 1 | A flow-control symbol is sent this cycle |
| fc_go | output | 1 | Symbol kind: 1 resume, 0 halt |
| link_go | output | 1 | Current link state: 1 resume, 0 halt |
| overflow_err | output | 1 | Sticky flag: a phit was dropped at full |

## Verification
The assertions treat `in_valid` as unconditional arrival: there is no backpressure at the input, so any phit presented at full must count as an overflow. The threshold properties rely on the fact that at most one phit enters and one leaves per cycle. For that reason a halt and a resume can never fall on back-to-back cycles. The stimulus keeps to this rule by driving inputs only once per cycle, just after the edge. In the streaming phase, the sender model obeys each symbol only after a fixed pipeline of RTT_CYCLES - 1 stages. Only the directed overflow phase ignores the halt state, and it does so on purpose.

// File: rtl/wm_flow_pkg.sv
package wm_flow_pkg;
   typedef enum logic {
      LINK_HALT   = 1'b0,
      LINK_RESUME = 1'b1
   } link_state_e;

   typedef struct packed {
      logic valid;
      logic go;
   } fc_sym_t;
endpackage

// File: rtl/wm_fifo_store.sv
module wm_fifo_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 32,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CW-1:0]     count,
   output logic              full,
   output logic              empty,
   output logic              accept
);
   localparam bit POW2 = (DEPTH == (1 << AW));
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   assign full   = (count == FULL_C);
   assign empty  = (count == '0);
   assign accept = push_req && (!full || pop);
   assign rdata  = mem[rd_ptr];

   generate
      if (POW2) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (accept) wr_ptr <= wr_nxt;
         if (pop)    rd_ptr <= rd_nxt;
         case ({accept, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/wm_hyst_ctrl.sv
module wm_hyst_ctrl
   import wm_flow_pkg::*;
#(
   parameter int CW        = 6,
   parameter int HIGH_MARK = 24,
   parameter int LOW_MARK  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   output link_state_e   state,
   output fc_sym_t       sym
);
   localparam logic [CW-1:0] HI_C = CW'(HIGH_MARK);
   localparam logic [CW-1:0] LO_C = CW'(LOW_MARK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LINK_RESUME;
         sym   <= '0;
      end else begin
         sym <= '0;
         if (state == LINK_RESUME && count >= HI_C) begin
            state <= LINK_HALT;
            sym   <= '{valid: 1'b1, go: 1'b0};
         end else if (state == LINK_HALT && count <= LO_C) begin
            state <= LINK_RESUME;
            sym   <= '{valid: 1'b1, go: 1'b1};
         end
      end
   end
endmodule

// File: rtl/wm_err_latch.sv
module wm_err_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
   end
endmodule

// File: rtl/wm_link_rx.sv
module wm_link_rx
   import wm_flow_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int DEPTH      = 32,
   parameter int HIGH_MARK  = 24,
   parameter int LOW_MARK   = 8,
   parameter int RTT_CYCLES = 6,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [LVL_W-1:0]  level,
   output logic              fc_valid,
   output logic              fc_go,
   output logic              link_go,
   output logic              overflow_err
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("wm_link_rx: DATA_W must be positive");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("wm_link_rx: DEPTH must be at least 2");
      end
      if (LOW_MARK >= HIGH_MARK) begin : g_bad_band
         $error("wm_link_rx: LOW_MARK must lie below HIGH_MARK");
      end
      if (DEPTH < HIGH_MARK + RTT_CYCLES + 1) begin : g_bad_slack
         $error("wm_link_rx: headroom above HIGH_MARK cannot absorb the round trip");
      end
   endgenerate

   logic        full, empty, accept, pop;
   link_state_e state;
   fc_sym_t     sym;

   assign pop       = out_ready && !empty;
   assign out_valid = !empty;

   wm_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (in_valid),
      .pop      (pop),
      .wdata    (in_data),
      .rdata    (out_data),
      .count    (level),
      .full     (full),
      .empty    (empty),
      .accept   (accept)
   );

   wm_hyst_ctrl #(.CW(LVL_W), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)) u_hyst (
      .clk   (clk),
      .rst_n (rst_n),
      .count (level),
      .state (state),
      .sym   (sym)
   );

   wm_err_latch u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (in_valid && !accept),
      .flag  (overflow_err)
   );

   assign fc_valid = sym.valid;
   assign fc_go    = sym.go;
   assign link_go  = (state == LINK_RESUME);
endmodule

// File: rtl/wm_link_rx_chk.sv
module wm_link_rx_chk #(
   parameter int DEPTH     = 32,
   parameter int HIGH_MARK = 24,
   parameter int LOW_MARK  = 8,
   parameter int LVL_W     = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             out_ready,
   input logic             out_valid,
   input logic [LVL_W-1:0] level,
   input logic             fc_valid,
   input logic             fc_go,
   input logic             link_go,
   input logic             overflow_err
);
   localparam logic [LVL_W-1:0] HI_C = LVL_W'(HIGH_MARK);
   localparam logic [LVL_W-1:0] LO_C = LVL_W'(LOW_MARK);
   localparam logic [LVL_W-1:0] DP_C = LVL_W'(DEPTH);

   p_valid_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (level != '0));

   p_halt_sym_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (link_go && level >= HI_C) |=> (fc_valid && !fc_go && !link_go));

   p_resume_sym_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_go && level <= LO_C) |=> (fc_valid && fc_go && link_go));

   p_single_sym_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fc_valid |=> !fc_valid);

   p_sym_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fc_valid |-> (link_go != $past(link_go)));

   p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      level <= DP_C);

   p_level_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (level == $past(level)) || (level == $past(level) + 1'b1)
      || (level + 1'b1 == $past(level)));

   p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && level == DP_C && !out_ready) |=> overflow_err);

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_err |=> overflow_err);
endmodule

bind wm_link_rx wm_link_rx_chk #(
   .DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK), .LVL_W(LVL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .out_ready    (out_ready),
   .out_valid    (out_valid),
   .level        (level),
   .fc_valid     (fc_valid),
   .fc_go        (fc_go),
   .link_go      (link_go),
   .overflow_err (overflow_err)
);

// File: tb/wm_link_rx_test.sv
module wm_link_rx_test;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 32;
   localparam int HIGH   = 24;
   localparam int LOW    = 8;
   localparam int RTT    = 6;
   localparam int LVL_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic              out_ready = 1'b0;
   logic              out_valid;
   logic [DATA_W-1:0] out_data;
   logic [LVL_W-1:0]  level;
   logic              fc_valid, fc_go, link_go, overflow_err;

   int checks = 0;
   int errors = 0;
   int halt_cnt = 0;
   int resume_cnt = 0;
   int max_level = 0;
   logic [DATA_W-1:0] sb_q[$];
   logic [DATA_W-1:0] seq = '0;

   always #5 clk = ~clk;

   wm_link_rx #(.DATA_W(DATA_W), .DEPTH(DEPTH), .HIGH_MARK(HIGH), .LOW_MARK(LOW),
                .RTT_CYCLES(RTT)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .level(level), .fc_valid(fc_valid), .fc_go(fc_go), .link_go(link_go),
      .overflow_err(overflow_err)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // driver: presents one phit and records it as expected output
   task automatic drive_phit(input bit expect_keep);
      in_valid = 1'b1;
      in_data  = seq;
      if (expect_keep) sb_q.push_back(seq);
      seq = seq + 1'b1;
   endtask

   // monitor: compares delivered phits, counts symbols, tracks occupancy
   always @(negedge clk) begin
      if (rst_n) begin
         if (int'(level) > max_level) max_level = int'(level);
         if (fc_valid) begin
            if (fc_go) resume_cnt++;
            else       halt_cnt++;
         end
         if (out_valid && out_ready) begin
            if (sb_q.size() == 0) begin
               check("R2 unexpected phit", int'(out_data), -1);
            end else begin
               check("R2 order", int'(out_data), int'(sb_q[0]));
               void'(sb_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic drain();
      in_valid  = 1'b0;
      out_ready = 1'b1;
      for (int k = 0; k < 200 && out_valid; k++) tick();
      tick();
   endtask

   initial begin
      int h0, g0;
      logic [1:0] pipe [RTT];
      logic allow;

      repeat (3) tick();
      // R1: state during and just after reset
      check("R1 level", int'(level), 0);
      check("R1 out_valid", int'(out_valid), 0);
      check("R1 link_go", int'(link_go), 1);
      check("R1 fc_valid", int'(fc_valid), 0);
      check("R1 overflow_err", int'(overflow_err), 0);
      rst_n = 1'b1;
      tick();
      check("R1 link_go after release", int'(link_go), 1);

      // R3: halt symbol timing
      out_ready = 1'b0;
      for (int i = 0; i < HIGH; i++) begin
         drive_phit(1'b1);
         tick();
         if (i == HIGH - 2) begin
            check("R3 no halt below mark", int'(fc_valid), 0);
            check("R6 level 23", int'(level), HIGH - 1);
         end
      end
      in_valid = 1'b0;
      check("R6 level at high mark", int'(level), HIGH);
      check("R3 halt one edge later", int'(fc_valid), 0);
      tick();
      check("R3 halt fc_valid", int'(fc_valid), 1);
      check("R3 halt fc_go", int'(fc_go), 0);
      check("R3 link_go low", int'(link_go), 0);
      tick();
      check("R3 halt is one cycle", int'(fc_valid), 0);
      check("R3 link_go held", int'(link_go), 0);

      // R4: resume symbol timing
      out_ready = 1'b1;
      for (int n = 1; n <= HIGH - LOW; n++) begin
         tick();
         if (n == HIGH - LOW - 1) begin
            check("R6 level 9", int'(level), LOW + 1);
            check("R5 no resume above mark", int'(fc_valid), 0);
            check("R5 still halted", int'(link_go), 0);
         end
      end
      check("R6 level at low mark", int'(level), LOW);
      check("R4 resume one edge later", int'(fc_valid), 0);
      tick();
      check("R4 resume fc_valid", int'(fc_valid), 1);
      check("R4 resume fc_go", int'(fc_go), 1);
      check("R4 link_go high", int'(link_go), 1);
      drain();
      check("R2 empty after drain", int'(out_valid), 0);
      check("R2 scoreboard empty", sb_q.size(), 0);

      // R5: motion inside the band sends nothing extra
      h0 = halt_cnt;
      g0 = resume_cnt;
      out_ready = 1'b0;
      for (int i = 0; i < HIGH; i++) begin drive_phit(1'b1); tick(); end
      in_valid = 1'b0;
      tick();
      tick();
      out_ready = 1'b1;
      repeat (4) tick();
      out_ready = 1'b0;
      check("R6 level inside band", int'(level), HIGH - 4);
      for (int i = 0; i < 10; i++) begin drive_phit(1'b1); tick(); end
      in_valid = 1'b0;
      tick();
      check("R5 halted while refilled", int'(link_go), 0);
      check("R5 single halt", halt_cnt - h0, 1);
      drain();
      tick();
      check("R5 single resume", resume_cnt - g0, 1);
      check("R5 single halt after drain", halt_cnt - h0, 1);
      check("R5 link_go resumed", int'(link_go), 1);

      // R8: streaming with a sender that obeys symbols after a delay
      h0 = halt_cnt;
      max_level = 0;
      allow = 1'b1;
      for (int s = 0; s < RTT; s++) pipe[s] = 2'b00;
      for (int cyc = 0; cyc < 3000; cyc++) begin
         out_ready = ((cyc % 3) == 0) || (((cyc / 500) % 2) == 1);
         if (allow) drive_phit(1'b1);
         else       in_valid = 1'b0;
         tick();
         for (int s = RTT - 1; s > 0; s--) pipe[s] = pipe[s-1];
         pipe[0] = {fc_valid, fc_go};
         if (pipe[RTT-1][1]) allow = pipe[RTT-1][0];
      end
      drain();
      check("R8 no overflow with delayed sender", int'(overflow_err), 0);
      check("R8 halts were issued", int'(halt_cnt - h0 > 0), 1);
      check("R8 reached high mark", int'(max_level >= HIGH), 1);
      check("R6 never above depth", int'(max_level <= DEPTH), 1);
      check("R2 stream scoreboard empty", sb_q.size(), 0);

      // R7: full buffer behaviour
      out_ready = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin drive_phit(1'b1); tick(); end
      check("R6 level full", int'(level), DEPTH);
      check("R7 no error yet", int'(overflow_err), 0);
      out_ready = 1'b1;
      drive_phit(1'b1);
      tick();
      check("R7 write with removal accepted", int'(level), DEPTH);
      check("R7 no error on write with removal", int'(overflow_err), 0);
      out_ready = 1'b0;
      drive_phit(1'b0);
      tick();
      in_valid = 1'b0;
      check("R7 error raised", int'(overflow_err), 1);
      check("R7 level unchanged by drop", int'(level), DEPTH);
      drain();
      check("R7 error sticky", int'(overflow_err), 1);
      check("R7 dropped phit absent", sb_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule